// File: doc/BRIEF.md
# Sixteen-Level Masked Interrupt Vectoring Unit

This unit collects sixteen interrupt request lines into a pending register and presents the most urgent request that is allowed through to the processor. Whether a request is allowed depends on three things: a sixteen-bit mask register that software writes, a global enable flag, and a fixed class for each level. Each level belongs to one of three classes: never blocked, blocked by its mask bit only, or blocked by its mask bit and by the global enable.

For the level it presents, the unit gives the level number and three addresses. The first is the address at which the instruction counter is loaded. The other two are the pointer words that hold the linkage and service addresses. The processor acknowledges a level once it has taken it, and this clears that level's pending bit. Masking a level hides it but does not discard it. Its pending bit stays set, so the level is presented once the mask allows it again.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the pending register and the mask are zero, the global enable is off, and `irq_valid_o` is low.
- R2: A request bit sampled high on a rising edge sets that level's pending bit. The bit stays set until an acknowledge names that level. The outputs reflect it one clock later.
- R3: `ack_i` with `ack_level_i` = n clears pending bit n. If a request for level n is sampled on the same edge, the bit stays set.
- R4: Among the eligible pending levels, the one with the lowest number is presented.
- R5: Levels 0 and 5 are eligible whenever they are pending, whatever the mask bits and the global enable.
- R6: Level 1 is eligible only when mask bit 1 is 1. The global enable has no effect on it.
- R7: Levels 2 to 4 and 6 to 15 are eligible only when their mask bit is 1 and the global enable is on.
- R8: A pending level that is masked stays pending. It is presented once its mask bit is set, without a new request.
- R9: The instruction-counter address output equals 16'h0400 + 4·level.
- R10: The linkage pointer output equals 16'h0020 + 2·level, and the service pointer output equals the linkage pointer plus 1.
- R11: A mask write with `mask_we_i` replaces the whole mask. Bit n = 1 means level n is unmasked. The new mask governs the outputs one clock after the write edge.
- R12: `en_set_i` turns the global enable on and `en_clr_i` turns it off. When both are high, the enable is turned off.
- R13: While `irq_valid_o` is low, the level output and all three address outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Request lines, one per level |
| ack_i | input | 1 | Acknowledge strobe |
| ack_level_i | input | 4 | Level being acknowledged |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 16 | New mask value, 1 = unmasked |
| en_set_i | input | 1 | Turn global enable on |
| en_clr_i | input | 1 | Turn global enable off |
| irq_valid_o | output | 1 | A level is being presented |
| irq_level_o | output | 4 | Presented level number |
| ic_addr_o | output | 16 | Instruction-counter load address |
| link_addr_o | output | 16 | Linkage pointer address |
| svc_addr_o | output | 16 | Service pointer address |

## Verification
A request sampled on edge k is in the pending register after edge k and reaches the outputs after edge k+1. Mask writes, enable commands and acknowledges also reach the outputs one edge after the edge that samples them. The bench model follows this timing. On every rising edge it first computes the output the design will register from the model's current state, then applies the inputs to that state. The bench drives inputs and compares outputs on falling edges, so each comparison checks a value that was registered half a cycle earlier. The checker holds two-stage delays of the inputs to test the same two-edge latency from the ports alone.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned NLVL     = 16;
  localparam int unsigned LVL_W    = $clog2(NLVL);
  localparam int unsigned ADDR_W   = 16;
  localparam logic [ADDR_W-1:0] IC_BASE  = 16'h0400;
  localparam int unsigned IC_SHIFT = 2;
  localparam logic [ADDR_W-1:0] PTR_BASE = 16'h0020;
  localparam int unsigned PTR_SHIFT = 1;
  // levels that ignore the mask bit
  localparam logic [NLVL-1:0] NOMASK_SET = 16'h0021;
  // levels that ignore the global enable
  localparam logic [NLVL-1:0] NODIS_SET  = 16'h0023;

  typedef enum logic [1:0] {
    CLS_ALWAYS = 2'd0,
    CLS_MASK   = 2'd1,
    CLS_FULL   = 2'd2
  } lvl_class_e;

  typedef struct packed {
    logic              valid;
    logic [LVL_W-1:0]  level;
    logic [ADDR_W-1:0] ic_addr;
    logic [ADDR_W-1:0] link_addr;
    logic [ADDR_W-1:0] svc_addr;
  } vec_out_t;
endpackage

// File: rtl/irqv_pend_reg.sv
module irqv_pend_reg #(
  parameter int unsigned NLVL  = 16,
  parameter int unsigned LVL_W = $clog2(NLVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NLVL-1:0]  req_i,
  input  logic             ack_i,
  input  logic [LVL_W-1:0] ack_level_i,
  output logic [NLVL-1:0]  pend_o
);
  logic [NLVL-1:0] ack_vec;

  always_comb begin
    ack_vec = '0;
    if (ack_i) ack_vec[ack_level_i] = 1'b1;
  end

  // a fresh request beats a clear of the same level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~ack_vec) | req_i;
  end
endmodule

// File: rtl/irqv_ctrl_reg.sv
module irqv_ctrl_reg #(
  parameter int unsigned NLVL = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mask_we_i,
  input  logic [NLVL-1:0] mask_wdata_i,
  input  logic            en_set_i,
  input  logic            en_clr_i,
  output logic [NLVL-1:0] mask_o,
  output logic            gie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      gie_o  <= 1'b0;
    end else begin
      if (mask_we_i) mask_o <= mask_wdata_i;
      if (en_clr_i)      gie_o <= 1'b0;
      else if (en_set_i) gie_o <= 1'b1;
    end
  end
endmodule

// File: rtl/irqv_filter.sv
module irqv_filter
  import irqv_pkg::*;
#(
  parameter int unsigned     NLVL       = 16,
  parameter logic [NLVL-1:0] NOMASK_SET = 16'h0021,
  parameter logic [NLVL-1:0] NODIS_SET  = 16'h0023
) (
  input  logic [NLVL-1:0] pend_i,
  input  logic [NLVL-1:0] mask_i,
  input  logic            gie_i,
  output logic [NLVL-1:0] elig_o
);
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam lvl_class_e CLS = NOMASK_SET[g] ? CLS_ALWAYS :
                                 NODIS_SET[g]  ? CLS_MASK   : CLS_FULL;
    if (CLS == CLS_ALWAYS) begin : g_always
      assign elig_o[g] = pend_i[g];
    end else if (CLS == CLS_MASK) begin : g_mask
      assign elig_o[g] = pend_i[g] & mask_i[g];
    end else begin : g_full
      assign elig_o[g] = pend_i[g] & mask_i[g] & gie_i;
    end
  end
endmodule

// File: rtl/irqv_vector.sv
module irqv_vector
  import irqv_pkg::*;
#(
  parameter int unsigned       NLVL      = 16,
  parameter int unsigned       LVL_W     = $clog2(NLVL),
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IC_BASE   = 16'h0400,
  parameter int unsigned       IC_SHIFT  = 2,
  parameter logic [ADDR_W-1:0] PTR_BASE  = 16'h0020,
  parameter int unsigned       PTR_SHIFT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLVL-1:0]   elig_i,
  output logic              valid_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [ADDR_W-1:0] ic_addr_o,
  output logic [ADDR_W-1:0] link_addr_o,
  output logic [ADDR_W-1:0] svc_addr_o
);
  logic              hit;
  logic [LVL_W-1:0]  win;
  logic [ADDR_W-1:0] lvl_ext, ic_n, link_n;

  // lowest number wins: scan down so the last hit is the smallest
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        hit = 1'b1;
        win = LVL_W'(i);
      end
    end
  end

  assign lvl_ext = ADDR_W'(win);
  assign ic_n    = IC_BASE  + (lvl_ext << IC_SHIFT);
  assign link_n  = PTR_BASE + (lvl_ext << PTR_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      level_o     <= '0;
      ic_addr_o   <= '0;
      link_addr_o <= '0;
      svc_addr_o  <= '0;
    end else if (hit) begin
      valid_o     <= 1'b1;
      level_o     <= win;
      ic_addr_o   <= ic_n;
      link_addr_o <= link_n;
      svc_addr_o  <= link_n | ADDR_W'(1);
    end else begin
      valid_o     <= 1'b0;
      level_o     <= '0;
      ic_addr_o   <= '0;
      link_addr_o <= '0;
      svc_addr_o  <= '0;
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int unsigned       N_LVL   = irqv_pkg::NLVL,
  parameter int unsigned       L_W     = $clog2(N_LVL),
  parameter int unsigned       A_W     = irqv_pkg::ADDR_W,
  parameter logic [A_W-1:0]    IC_B    = irqv_pkg::IC_BASE,
  parameter logic [A_W-1:0]    PTR_B   = irqv_pkg::PTR_BASE,
  parameter logic [N_LVL-1:0]  NOMASK  = irqv_pkg::NOMASK_SET,
  parameter logic [N_LVL-1:0]  NODIS   = irqv_pkg::NODIS_SET
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] req_i,
  input  logic             ack_i,
  input  logic [L_W-1:0]   ack_level_i,
  input  logic             mask_we_i,
  input  logic [N_LVL-1:0] mask_wdata_i,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  output logic             irq_valid_o,
  output logic [L_W-1:0]   irq_level_o,
  output logic [A_W-1:0]   ic_addr_o,
  output logic [A_W-1:0]   link_addr_o,
  output logic [A_W-1:0]   svc_addr_o
);
  logic [N_LVL-1:0] pend, mask, elig;
  logic             gie;

  irqv_pend_reg #(.NLVL(N_LVL), .LVL_W(L_W)) u_pend (
    .clk_i, .rst_ni, .req_i, .ack_i, .ack_level_i, .pend_o(pend)
  );

  irqv_ctrl_reg #(.NLVL(N_LVL)) u_ctrl (
    .clk_i, .rst_ni, .mask_we_i, .mask_wdata_i, .en_set_i, .en_clr_i,
    .mask_o(mask), .gie_o(gie)
  );

  irqv_filter #(.NLVL(N_LVL), .NOMASK_SET(NOMASK), .NODIS_SET(NODIS)) u_filt (
    .pend_i(pend), .mask_i(mask), .gie_i(gie), .elig_o(elig)
  );

  irqv_vector #(
    .NLVL(N_LVL), .LVL_W(L_W), .ADDR_W(A_W),
    .IC_BASE(IC_B), .IC_SHIFT(irqv_pkg::IC_SHIFT),
    .PTR_BASE(PTR_B), .PTR_SHIFT(irqv_pkg::PTR_SHIFT)
  ) u_vec (
    .clk_i, .rst_ni, .elig_i(elig),
    .valid_o(irq_valid_o), .level_o(irq_level_o),
    .ic_addr_o, .link_addr_o, .svc_addr_o
  );
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int unsigned       N_LVL  = 16,
  parameter int unsigned       L_W    = 4,
  parameter int unsigned       A_W    = 16,
  parameter logic [A_W-1:0]    IC_B   = 16'h0400,
  parameter logic [A_W-1:0]    PTR_B  = 16'h0020,
  parameter logic [N_LVL-1:0]  NOMASK = 16'h0021,
  parameter logic [N_LVL-1:0]  NODIS  = 16'h0023
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_LVL-1:0] req_i,
  input logic             mask_we_i,
  input logic [N_LVL-1:0] mask_wdata_i,
  input logic             en_clr_i,
  input logic             irq_valid_o,
  input logic [L_W-1:0]   irq_level_o,
  input logic [A_W-1:0]   ic_addr_o,
  input logic [A_W-1:0]   link_addr_o,
  input logic [A_W-1:0]   svc_addr_o
);
  logic [N_LVL-1:0] req_d1, req_d2, wd_d1, wd_d2;
  logic             we_d1, we_d2, clr_d1, clr_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d1 <= '0; req_d2 <= '0; wd_d1 <= '0; wd_d2 <= '0;
      we_d1 <= 1'b0; we_d2 <= 1'b0; clr_d1 <= 1'b0; clr_d2 <= 1'b0;
    end else begin
      req_d1 <= req_i;        req_d2 <= req_d1;
      wd_d1  <= mask_wdata_i; wd_d2  <= wd_d1;
      we_d1  <= mask_we_i;    we_d2  <= we_d1;
      clr_d1 <= en_clr_i;     clr_d2 <= clr_d1;
    end
  end

  // R13
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_o |-> (irq_level_o == '0 && ic_addr_o == '0 &&
                      link_addr_o == '0 && svc_addr_o == '0));

  // R10
  svc_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (svc_addr_o == link_addr_o + A_W'(1)));

  // R9
  ic_vs_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> ((ic_addr_o - IC_B) == ((link_addr_o - PTR_B) << 1)));

  // R5
  top_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_d2[0] |-> (irq_valid_o && irq_level_o == '0));

  // R12
  disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_d2 && irq_valid_o) |-> NODIS[irq_level_o]);

  // R11
  mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_d2 && irq_valid_o) |-> (NOMASK[irq_level_o] || wd_d2[irq_level_o]));
endmodule

bind irq_vector_unit irqv_chk #(
  .N_LVL(N_LVL), .L_W(L_W), .A_W(A_W), .IC_B(IC_B), .PTR_B(PTR_B),
  .NOMASK(NOMASK), .NODIS(NODIS)
) u_chk (
  .clk_i, .rst_ni, .req_i, .mask_we_i, .mask_wdata_i, .en_clr_i,
  .irq_valid_o, .irq_level_o, .ic_addr_o, .link_addr_o, .svc_addr_o
);

// File: tb/irq_vector_unit_test.sv
`timescale 1ns/1ps
module irq_vector_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        ack = 1'b0;
  logic [3:0]  ack_lvl = '0;
  logic        mwe = 1'b0;
  logic [15:0] mwd = '0;
  logic        eset = 1'b0, eclr = 1'b0;
  logic        v;
  logic [3:0]  lvl;
  logic [15:0] ic, lk, sv;

  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";
  bit done = 1'b0;

  // reference state
  bit [15:0] m_pend, m_mask;
  bit        m_gie;
  bit        e_v;
  int        e_lvl, e_ic, e_lk, e_sv;

  irq_vector_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ack_i(ack), .ack_level_i(ack_lvl),
    .mask_we_i(mwe), .mask_wdata_i(mwd), .en_set_i(eset), .en_clr_i(eclr),
    .irq_valid_o(v), .irq_level_o(lvl), .ic_addr_o(ic), .link_addr_o(lk),
    .svc_addr_o(sv)
  );

  always #10 clk = ~clk;

  function automatic bit allowed(int n);
    if (n == 0 || n == 5) return 1'b1;          // R5
    if (n == 1) return m_mask[1];               // R6
    return m_mask[n] && m_gie;                  // R7
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_mask = '0; m_gie = 0;
      e_v = 0; e_lvl = 0; e_ic = 0; e_lk = 0; e_sv = 0;
    end else begin
      e_v = 0; e_lvl = 0; e_ic = 0; e_lk = 0; e_sv = 0;
      for (int n = 0; n < 16; n++) begin
        if (!e_v && m_pend[n] && allowed(n)) begin  // R4
          e_v = 1; e_lvl = n;
          e_ic = 'h400 + 4 * n;                     // R9
          e_lk = 'h20 + 2 * n;                      // R10
          e_sv = e_lk + 1;
        end
      end
      if (ack) m_pend[ack_lvl] = 0;                 // R3
      m_pend = m_pend | req;                        // R2
      if (mwe) m_mask = mwd;                        // R11
      if (eclr) m_gie = 0;                          // R12
      else if (eset) m_gie = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (v !== e_v || int'(lvl) != e_lvl || int'(ic) != e_ic ||
          int'(lk) != e_lk || int'(sv) != e_sv) begin
        bad++;
        $display("FAIL %s cyc=%0d actual v=%0b lvl=%0d ic=%h lk=%h sv=%h expected v=%0b lvl=%0d ic=%h lk=%h sv=%h",
                 tag, cyc, v, lvl, ic, lk, sv, e_v, e_lvl, e_ic[15:0], e_lk[15:0], e_sv[15:0]);
      end
    end
    cyc++;
  end

  task automatic step(int k = 1);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask
  task automatic pulse_req(logic [15:0] r);
    req = r; step(); req = '0;
  endtask
  task automatic do_ack(int n);
    ack = 1; ack_lvl = 4'(n); step(); ack = 0;
  endtask
  task automatic wr_mask(logic [15:0] m);
    mwe = 1; mwd = m; step(); mwe = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1: outputs idle out of reset
    tag = "R1"; step(2);
    // R7: masked/disabled level stays hidden; R5 level 0 fires regardless
    tag = "R7"; pulse_req(16'h0008); step(3);
    tag = "R5"; pulse_req(16'h0001); step(3);
    do_ack(0); step(2);
    pulse_req(16'h0020); step(3); do_ack(5); step(2);
    // R6: level 1 needs its mask bit but not the enable
    tag = "R6"; pulse_req(16'h0002); step(3);
    tag = "R11"; wr_mask(16'hFFFF); step(3);
    do_ack(1); step(2);
    // R8: level 3 still pending, shows once enabled
    tag = "R8"; eset = 1; step(); eset = 0; step(3);
    // R11: masking hides it again, unmasking restores it
    tag = "R11"; wr_mask(16'hFFF7); step(3);
    wr_mask(16'hFFFF); step(2);
    do_ack(3); step(2);
    // R4 / R9 / R10: all levels pending, walk down by acknowledges
    tag = "R4"; pulse_req(16'hFFFF); step(2);
    for (int n = 0; n < 16; n++) begin
      tag = (n % 2) ? "R9" : "R10";
      do_ack(n); step();
    end
    step(2);
    // R12: set and clear together leave enable off
    tag = "R12"; pulse_req(16'h0110); step(2);
    eset = 1; eclr = 1; step(); eset = 0; eclr = 0; step(3);
    eset = 1; step(); eset = 0; step(3);
    eclr = 1; step(); eclr = 0; step(3);
    eset = 1; step(); eset = 0; step(2);
    // R3: request and ack of the same level on one edge keeps the bit
    tag = "R3"; req = 16'h0010; ack = 1; ack_lvl = 4; step();
    req = '0; ack = 0; step(3);
    do_ack(4); step(3);
    do_ack(8); step(3);
    // R2: single pulse held until acknowledged
    tag = "R2"; pulse_req(16'h4000); step(6);
    do_ack(14); step(3);
    // R13: idle zero, priority with mixed mask
    tag = "R13"; wr_mask(16'h0000); pulse_req(16'hFFDE); step(4);
    for (int n = 0; n < 16; n++) do_ack(n);
    step(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule